// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits beside the 64-bit ECC datapath of a memory controller and does two jobs. On the write side it can flip chosen data and check bits on every beat, so that error paths can be exercised on purpose. On the read side it watches the per-beat status from the ECC decoder and records what it sees. A multi-bit error is reported at once. Single-bit errors are counted, and one is reported only when the count reaches a programmable threshold. The details of the first reported error are frozen until software clears the status.

Software reaches the unit through a small word-addressed register port. The port has a write strobe and a registered read path. The interrupt line is a level. It stays high for as long as a status flag with its enable set is present.

Top module: `ecc_err_monitor`

## Requirements
- R1: The status register (address 0) holds sticky flags, bit 0 for a single-bit error and bit 1 for a multi-bit error. Writing a 1 to a bit clears that flag. Writing 3 clears both flags. Writing a 0 leaves a flag unchanged.
- R2: A flag that is set by a read beat on the same clock edge as a software clear ends up set.
- R3: A read beat marked multi-bit sets status bit 1 on the next clock edge, whatever the threshold setting.
- R4: The management register (address 3) has two fields. Bits 7:0 are a counter that increments on each counted single-bit beat. Bits 23:16 are a threshold. When the incremented count equals a nonzero threshold, status bit 0 is set and the counter returns to 0. With a threshold of 0 the counter keeps counting and never sets the flag.
- R5: The interrupt output equals the OR of (status & enable) on every clock edge. The enable register is at address 1, with bit 0 for single-bit errors and bit 1 for multi-bit errors.
- R6: The disable register (address 2) suppresses one error type per bit. Bit 0 suppresses single-bit errors and bit 1 suppresses multi-bit errors. A suppressed beat does not count, does not set a flag and does not capture. Writing 0 to the register enables all checks.
- R7: The capture registers load from a beat that sets a flag while both flags are clear. At any other time they hold their values. Their addresses are: data bits 63:32 at 4, data bits 31:0 at 5, check bits at 6, address bits 31:0 at 7 and address bits above 31 at 8.
- R8: In the wide bus mode (the default), only check bits 7:0 are captured. In the narrow mode, bits 15:0 are captured. The upper bits read as 0.
- R9: When bit 9 of the injection control register (address 11) is set, write data leaves the block XORed with the mask registers. The mask for bits 63:32 is at address 9 and the mask for bits 31:0 is at address 10. The check bits leave XORed with control bits 7:0. When bit 9 is clear, data and check bits pass through unchanged. In both cases the output follows the input by one cycle.
- R10: Read data appears on the cycle after the address is presented. The injection registers read back as they were written.
- R11: A software write to the management register on the same edge as a counted single-bit beat takes priority. The written values are kept, the beat is not counted and it does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| wr_valid_in | input | 1 | Write beat valid |
| wr_data_in | input | DATA_W | Write data from the encoder |
| wr_ecc_in | input | WECC_W | Check bits from the encoder |
| wr_valid_out | output | 1 | Write beat valid, delayed one cycle |
| wr_data_out | output | DATA_W | Write data after injection |
| wr_ecc_out | output | WECC_W | Check bits after injection |
| rd_valid | input | 1 | Read beat status valid |
| rd_sbe | input | 1 | Beat had a corrected single-bit error |
| rd_mbe | input | 1 | Beat had an uncorrectable error |
| rd_addr | input | ADDR_W | Address of the beat |
| rd_data | input | DATA_W | Raw data of the beat |
| rd_ecc | input | RECC_W | Raw check bits of the beat |
| irq | output | 1 | Level interrupt |

## Verification
Two clashes can fall in one cycle. In the first, a read beat raises a flag while software writes ones to clear that same flag. In the second, a single-bit beat arrives in the cycle that software rewrites the management register. The bench provokes each clash by driving the register write and the read beat on the same clock. For the first clash it then reads the status back and expects the flag still set. For the second it reads the management register and expects exactly the written counter and threshold, with no increment from the beat.

// File: rtl/eccmon_pkg.sv
package eccmon_pkg;
  localparam int REG_AW   = 4;
  localparam int REG_DW   = 32;
  localparam int CNT_W    = 8;
  localparam int CNT_LSB  = 0;
  localparam int THR_LSB  = 16;
  localparam int INJ_EN   = 9;
  localparam int FLAG_SBE = 0;
  localparam int FLAG_MBE = 1;

  typedef enum logic [REG_AW-1:0] {
    RA_STATUS  = 4'd0,
    RA_IRQ_EN  = 4'd1,
    RA_DISABLE = 4'd2,
    RA_SBE_MGT = 4'd3,
    RA_CAP_DHI = 4'd4,
    RA_CAP_DLO = 4'd5,
    RA_CAP_ECC = 4'd6,
    RA_CAP_ALO = 4'd7,
    RA_CAP_AHI = 4'd8,
    RA_INJ_HI  = 4'd9,
    RA_INJ_LO  = 4'd10,
    RA_INJ_CTL = 4'd11
  } reg_addr_e;
endpackage

// File: rtl/eccmon_inject.sv
module eccmon_inject #(
  parameter int DW = 64,
  parameter int EW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] dmask,
  input  logic [EW-1:0] emask,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic [EW-1:0] in_ecc,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [EW-1:0] out_ecc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ecc   <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= en ? (in_data ^ dmask) : in_data;
      out_ecc   <= en ? (in_ecc ^ emask) : in_ecc;
    end
  end
endmodule

// File: rtl/eccmon_sbe_ctr.sv
module eccmon_sbe_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          sw_wr,
  input  logic [CW-1:0] sw_cnt,
  input  logic [CW-1:0] sw_thr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] thr,
  output logic          raise
);
  logic [CW-1:0] cnt_inc;
  logic          reach;

  always_comb begin
    cnt_inc = cnt + CW'(1);
    reach   = (thr != '0) && (cnt_inc == thr);
    raise   = hit && !sw_wr && reach;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      thr <= '0;
    end else if (sw_wr) begin
      cnt <= sw_cnt;
      thr <= sw_thr;
    end else if (hit) begin
      cnt <= reach ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/eccmon_capture.sv
module eccmon_capture #(
  parameter int DW     = 64,
  parameter int AW     = 40,
  parameter int EW     = 16,
  parameter bit NARROW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] data,
  input  logic [EW-1:0] ecc,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] cap_data,
  output logic [EW-1:0] cap_ecc,
  output logic [AW-1:0] cap_addr
);
  logic [EW-1:0] ecc_kept;

  generate
    if (NARROW) begin : g_narrow
      assign ecc_kept = ecc & EW'((1 << 16) - 1);
    end else begin : g_wide
      assign ecc_kept = ecc & EW'((1 << 8) - 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data <= '0;
      cap_ecc  <= '0;
      cap_addr <= '0;
    end else if (load) begin
      cap_data <= data;
      cap_ecc  <= ecc_kept;
      cap_addr <= addr;
    end
  end
endmodule

// File: rtl/ecc_err_monitor.sv
module ecc_err_monitor
  import eccmon_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 40,
  parameter int WECC_W     = 8,
  parameter int RECC_W     = 16,
  parameter bit NARROW_BUS = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              wr_valid_in,
  input  logic [DATA_W-1:0] wr_data_in,
  input  logic [WECC_W-1:0] wr_ecc_in,
  output logic              wr_valid_out,
  output logic [DATA_W-1:0] wr_data_out,
  output logic [WECC_W-1:0] wr_ecc_out,
  input  logic              rd_valid,
  input  logic              rd_sbe,
  input  logic              rd_mbe,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [RECC_W-1:0] rd_ecc,
  output logic              irq
);
  localparam int HALF_W = DATA_W / 2;

  reg_addr_e    ra;
  logic [1:0]   flags_q, flags_d, irq_en_q, irq_en_d, dis_q, set_v, clr_v;
  logic [31:0]  inj_hi_q, inj_lo_q, inj_ctl_q, rd_mux;
  logic         sbe_ev, mbe_ev, sbe_raise, cap_load, inj_on;
  logic [CNT_W-1:0] sbe_cnt, sbe_thr;
  logic [DATA_W-1:0] cap_data;
  logic [RECC_W-1:0] cap_ecc;
  logic [ADDR_W-1:0] cap_addr;
  logic [31:0]  cap_dlo;

  assign ra      = reg_addr_e'(reg_addr);
  assign sbe_ev  = rd_valid && rd_sbe && !dis_q[FLAG_SBE];
  assign mbe_ev  = rd_valid && rd_mbe && !dis_q[FLAG_MBE];
  assign inj_on  = inj_ctl_q[INJ_EN];
  assign cap_dlo = cap_data[31:0];

  eccmon_sbe_ctr #(.CW(CNT_W)) u_sbe_ctr (
    .clk(clk), .rst(rst), .hit(sbe_ev),
    .sw_wr(reg_wr && ra == RA_SBE_MGT),
    .sw_cnt(reg_wdata[CNT_LSB +: CNT_W]),
    .sw_thr(reg_wdata[THR_LSB +: CNT_W]),
    .cnt(sbe_cnt), .thr(sbe_thr), .raise(sbe_raise)
  );

  always_comb begin
    set_v    = 2'b00;
    set_v[FLAG_SBE] = sbe_raise;
    set_v[FLAG_MBE] = mbe_ev;
    clr_v    = (reg_wr && ra == RA_STATUS) ? reg_wdata[1:0] : 2'b00;
    flags_d  = (flags_q & ~clr_v) | set_v;
    irq_en_d = (reg_wr && ra == RA_IRQ_EN) ? reg_wdata[1:0] : irq_en_q;
    cap_load = (set_v != 2'b00) && (flags_q == 2'b00);
  end

  eccmon_capture #(.DW(DATA_W), .AW(ADDR_W), .EW(RECC_W), .NARROW(NARROW_BUS)) u_capture (
    .clk(clk), .rst(rst), .load(cap_load),
    .data(rd_data), .ecc(rd_ecc), .addr(rd_addr),
    .cap_data(cap_data), .cap_ecc(cap_ecc), .cap_addr(cap_addr)
  );

  eccmon_inject #(.DW(DATA_W), .EW(WECC_W)) u_inject (
    .clk(clk), .rst(rst), .en(inj_on),
    .dmask({inj_hi_q[HALF_W-1:0], inj_lo_q[HALF_W-1:0]}),
    .emask(inj_ctl_q[WECC_W-1:0]),
    .in_valid(wr_valid_in), .in_data(wr_data_in), .in_ecc(wr_ecc_in),
    .out_valid(wr_valid_out), .out_data(wr_data_out), .out_ecc(wr_ecc_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q   <= '0;
      irq_en_q  <= '0;
      dis_q     <= '0;
      inj_hi_q  <= '0;
      inj_lo_q  <= '0;
      inj_ctl_q <= '0;
      irq       <= 1'b0;
    end else begin
      flags_q  <= flags_d;
      irq_en_q <= irq_en_d;
      irq      <= |(flags_d & irq_en_d);
      if (reg_wr) begin
        case (ra)
          RA_DISABLE: dis_q     <= reg_wdata[1:0];
          RA_INJ_HI:  inj_hi_q  <= reg_wdata;
          RA_INJ_LO:  inj_lo_q  <= reg_wdata;
          RA_INJ_CTL: inj_ctl_q <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (ra)
      RA_STATUS:  rd_mux = {30'b0, flags_q};
      RA_IRQ_EN:  rd_mux = {30'b0, irq_en_q};
      RA_DISABLE: rd_mux = {30'b0, dis_q};
      RA_SBE_MGT: rd_mux = (32'(sbe_thr) << THR_LSB) | (32'(sbe_cnt) << CNT_LSB);
      RA_CAP_DHI: rd_mux = cap_data[DATA_W-1:HALF_W];
      RA_CAP_DLO: rd_mux = cap_data[HALF_W-1:0];
      RA_CAP_ECC: rd_mux = 32'(cap_ecc);
      RA_CAP_ALO: rd_mux = cap_addr[31:0];
      RA_CAP_AHI: rd_mux = 32'(cap_addr[ADDR_W-1:32]);
      RA_INJ_HI:  rd_mux = inj_hi_q;
      RA_INJ_LO:  rd_mux = inj_lo_q;
      RA_INJ_CTL: rd_mux = inj_ctl_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/eccmon_checker.sv
module eccmon_checker #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic          wbit0,
  input logic          rd_valid,
  input logic          rd_mbe,
  input logic          wr_valid_in,
  input logic [DW-1:0] wr_data_in,
  input logic [DW-1:0] wr_data_out,
  input logic          irq,
  input logic [1:0]    flags_q,
  input logic [1:0]    irq_en_q,
  input logic [1:0]    dis_q,
  input logic          inj_on,
  input logic [31:0]   cap_dlo
);
  AST_SBE_STICKY: assert property (@(posedge clk) disable iff (rst)
    flags_q[0] && !(reg_wr && reg_addr == 4'd0 && wbit0) |=> flags_q[0]); // R1
  AST_MBE_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_mbe && !dis_q[1] |=> flags_q[1]); // R3
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags_q & irq_en_q)); // R5
  AST_MBE_SUPPRESSED: assert property (@(posedge clk) disable iff (rst)
    rd_valid && rd_mbe && dis_q[1] && !flags_q[1] |=> !flags_q[1]); // R6
  AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    flags_q != 2'b00 |=> $stable(cap_dlo)); // R7
  AST_INJECT_PASS: assert property (@(posedge clk) disable iff (rst)
    wr_valid_in && !inj_on |=> wr_data_out == $past(wr_data_in)); // R9
endmodule

bind ecc_err_monitor eccmon_checker #(.DW(DATA_W)) u_eccmon_checker (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .wbit0(reg_wdata[0]),
  .rd_valid(rd_valid), .rd_mbe(rd_mbe), .wr_valid_in(wr_valid_in),
  .wr_data_in(wr_data_in), .wr_data_out(wr_data_out), .irq(irq),
  .flags_q(flags_q), .irq_en_q(irq_en_q), .dis_q(dis_q), .inj_on(inj_on),
  .cap_dlo(cap_dlo)
);

// File: tb/test_ecc_err_monitor.sv
module test_ecc_err_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        wr_valid_in = 1'b0;
  logic [63:0] wr_data_in = '0;
  logic [7:0]  wr_ecc_in = '0;
  logic        wr_valid_out;
  logic [63:0] wr_data_out;
  logic [7:0]  wr_ecc_out;
  logic        rd_valid = 1'b0, rd_sbe = 1'b0, rd_mbe = 1'b0;
  logic [39:0] rd_addr = '0;
  logic [63:0] rd_data = '0;
  logic [15:0] rd_ecc = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ecc_err_monitor i_ecc_err_monitor (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wr_valid_in(wr_valid_in), .wr_data_in(wr_data_in),
    .wr_ecc_in(wr_ecc_in), .wr_valid_out(wr_valid_out), .wr_data_out(wr_data_out),
    .wr_ecc_out(wr_ecc_out), .rd_valid(rd_valid), .rd_sbe(rd_sbe), .rd_mbe(rd_mbe),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_ecc(rd_ecc), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic beat(input logic s, input logic m, input logic [39:0] a,
                      input logic [63:0] d, input logic [15:0] e);
    @(negedge clk);
    rd_valid = 1'b1; rd_sbe = s; rd_mbe = m; rd_addr = a; rd_data = d; rd_ecc = e;
    @(negedge clk);
    rd_valid = 1'b0; rd_sbe = 1'b0; rd_mbe = 1'b0;
  endtask

  task automatic beat_with_write(input logic s, input logic m, input logic [3:0] a,
                                 input logic [31:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_sbe = s; rd_mbe = m; rd_data = 64'hFEED;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    rd_valid = 1'b0; rd_sbe = 1'b0; rd_mbe = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] dm, din;
    logic [7:0]  em;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state
    rd_reg(4'd0, v);  chk("R1 reset status", v, 0);
    rd_reg(4'd3, v);  chk("R4 reset mgt", v, 0);
    rd_reg(4'd11, v); chk("R9 reset inj ctl", v, 0);
    chk("R5 reset irq", irq, 0);

    // R9 injection sweep over every data bit
    for (int i = 0; i < 64; i++) begin
      dm  = 64'd1 << i;
      em  = 8'(i * 7);
      din = {32'hA5A5_0000 | 32'(i), 32'h1234_5678 ^ 32'(i)};
      wr_reg(4'd9, dm[63:32]);
      wr_reg(4'd10, dm[31:0]);
      wr_reg(4'd11, 32'h200 | 32'(em));
      @(negedge clk);
      wr_valid_in = 1'b1; wr_data_in = din; wr_ecc_in = 8'(i);
      @(negedge clk);
      wr_valid_in = 1'b0;
      chk("R9 inject data", wr_data_out, din ^ dm);
      chk("R9 inject ecc", {56'b0, wr_ecc_out}, {56'b0, 8'(i) ^ em});
      chk("R9 valid delay", wr_valid_out, 1);
    end
    rd_reg(4'd9, v);  chk("R10 readback inj hi", v, 32'h8000_0000);
    rd_reg(4'd10, v); chk("R10 readback inj lo", v, 0);
    wr_reg(4'd11, 32'h0000_00FF);
    @(negedge clk);
    wr_valid_in = 1'b1; wr_data_in = 64'h0F0F_1234_5555_AAAA; wr_ecc_in = 8'h3C;
    @(negedge clk);
    wr_valid_in = 1'b0;
    chk("R9 pass data", wr_data_out, 64'h0F0F_1234_5555_AAAA);
    chk("R9 pass ecc", {56'b0, wr_ecc_out}, 64'h3C);
    rd_reg(4'd11, v); chk("R10 readback inj ctl", v, 32'hFF);

    // R4 threshold sweep with R7 capture of the reporting beat
    wr_reg(4'd1, 3);
    for (int t = 1; t <= 4; t++) begin
      wr_reg(4'd3, 32'(t) << 16);
      for (int k = 1; k <= t; k++) begin
        beat(1'b1, 1'b0, 40'h12_0000_0000 | 40'(t * 16 + k),
             {32'hC0DE_0000 | 32'(t), 32'h0BAD_0000 | 32'(k)}, 16'(k));
        rd_reg(4'd0, v);
        if (k < t) begin
          chk("R4 below threshold flag", v, 0);
          rd_reg(4'd3, v); chk("R4 count", v, (32'(t) << 16) | 32'(k));
        end else begin
          chk("R4 threshold reached flag", v, 1);
          chk("R5 irq on sbe", irq, 1);
          rd_reg(4'd3, v); chk("R4 count reset", v, 32'(t) << 16);
          rd_reg(4'd5, v); chk("R7 capture data lo", v, 32'h0BAD_0000 | 32'(t));
          rd_reg(4'd7, v); chk("R7 capture addr lo", v, 32'(t * 16 + t));
          rd_reg(4'd8, v); chk("R7 capture addr hi", v, 32'h12);
        end
      end
      wr_reg(4'd0, 3);
      rd_reg(4'd0, v); chk("R1 clear all", v, 0);
      chk("R5 irq drops", irq, 0);
    end

    // R4 threshold zero never reports
    wr_reg(4'd3, 0);
    for (int k = 0; k < 3; k++) beat(1'b1, 1'b0, 40'h0, 64'h0, 16'h0);
    rd_reg(4'd3, v); chk("R4 zero threshold count", v, 3);
    rd_reg(4'd0, v); chk("R4 zero threshold flag", v, 0);

    // R3 multi-bit, R7 capture, R8 check-bit width
    beat(1'b0, 1'b1, 40'hAB_DEAD_BEE0, 64'h0123_4567_89AB_CDEF, 16'hABCD);
    rd_reg(4'd0, v); chk("R3 mbe flag", v, 2);
    chk("R5 irq on mbe", irq, 1);
    rd_reg(4'd4, v); chk("R7 capture data hi", v, 32'h0123_4567);
    rd_reg(4'd6, v); chk("R8 capture ecc wide", v, 32'hCD);
    rd_reg(4'd7, v); chk("R7 capture addr lo mbe", v, 32'hDEAD_BEE0);
    wr_reg(4'd3, 32'h0001_0000);
    beat(1'b1, 1'b1, 40'h1, 64'h1111_2222_3333_4444, 16'h0);
    rd_reg(4'd5, v); chk("R7 capture held", v, 32'h89AB_CDEF);
    rd_reg(4'd0, v); chk("R1 both flags", v, 3);
    wr_reg(4'd0, 1);
    rd_reg(4'd0, v); chk("R1 clear sbe only", v, 2);
    wr_reg(4'd0, 0);
    rd_reg(4'd0, v); chk("R1 zero write keeps", v, 2);
    wr_reg(4'd0, 3);

    // R6 disables
    wr_reg(4'd2, 1);
    beat(1'b1, 1'b0, 40'h5, 64'h5, 16'h5);
    rd_reg(4'd0, v); chk("R6 sbe suppressed flag", v, 0);
    rd_reg(4'd3, v); chk("R6 sbe suppressed count", v, 32'h0001_0000);
    wr_reg(4'd2, 2);
    beat(1'b0, 1'b1, 40'h6, 64'h6, 16'h6);
    rd_reg(4'd0, v); chk("R6 mbe suppressed flag", v, 0);
    rd_reg(4'd5, v); chk("R6 no capture", v, 32'h89AB_CDEF);
    wr_reg(4'd2, 0);

    // R5 enables
    wr_reg(4'd1, 0);
    beat(1'b0, 1'b1, 40'h7, 64'h7, 16'h7);
    chk("R5 irq masked", irq, 0);
    wr_reg(4'd1, 2);
    chk("R5 irq enabled", irq, 1);
    wr_reg(4'd1, 1);
    chk("R5 irq other enable", irq, 0);
    wr_reg(4'd0, 3);
    wr_reg(4'd1, 3);

    // R2 set beats simultaneous clear
    beat_with_write(1'b1, 1'b1, 4'd0, 3);
    rd_reg(4'd0, v); chk("R2 set wins over clear", v, 3);
    wr_reg(4'd0, 3);

    // R11 management write wins over counted beat
    wr_reg(4'd3, 32'h0005_0002);
    beat_with_write(1'b1, 1'b0, 4'd3, 32'h0005_0000);
    rd_reg(4'd3, v); chk("R11 write priority", v, 32'h0005_0000);
    rd_reg(4'd0, v); chk("R11 no flag", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule